// File: doc/BRIEF.md
# Pipelined Crossbar Switch Allocator

This block joins a set of requesting ports to a set of destination ports through a crossbar. The default size is 8 requesting ports and 9 destination ports: 8 cache banks and one I/O port. In every cycle each requesting port may present a data word and a vector naming the outputs it would accept. The block settles the conflicts with a separable round-robin allocator. It tells each winner that it won, and then drives each word out on the chosen output.

Work moves through four register stages. The first stage captures requests. The second computes the grant matrix. The third sends the notice to winners and holds the switch settings. The fourth moves the data. A fresh batch can enter every cycle, so one set of transfers finishes per cycle, and every input/output pair has the same latency. Each batch stands alone. A port that loses is not held over, and it simply presents its request again in a later cycle.

Top module: `xsw_crossbar`

## Requirements
- R1: While rst_n is low, in_grant, out_valid, out_data and out_src are all zero, and every round-robin pointer returns to index 0.
- R2: Input i requests output j when in_valid[i] is 1 and bit i*N_OUT+j of in_dest is 1. When in_valid[i] is 0, the in_dest and in_data bits of that input have no effect on any output or pointer.
- R3: A word presented in the cycle before rising edge e appears on its granted output right after edge e+3. The delay is the same for every input/output pair.
- R4: in_grant[i] goes to 1 right after edge e+2 exactly when input i won an output in the batch captured at edge e.
- R5: Within one batch each input wins at most one output and each output accepts at most one input.
- R6: In the first pass, each output offers itself to the first requesting input found by scanning upward from its own pointer and wrapping past N_IN-1 to 0.
- R7: In the second pass, each input that receives offers accepts the first offering output found by scanning upward from its own pointer and wrapping past N_OUT-1 to 0.
- R8: On an acceptance of input i by output j, the output pointer moves to i+1 and the input pointer moves to j+1, each modulo its port count. Pointers that take part in no accepted grant keep their value.
- R9: An output with no grant in a batch drives out_valid 0, out_data 0 and out_src 0 in that batch's delivery cycle.
- R10: When out_valid[j] is 1, out_src field j (bits j*SW upward) holds the index of the input whose word is on out_data field j (bits j*DW upward).
- R11: A new batch is accepted on every edge with no gaps. Requests that lose are dropped and do not reach later batches.
- R12: If all inputs keep requesting only one output for N_IN consecutive batches, each of them is delivered once on that output within those batches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | N_IN (8) | Per-input request strobe |
| in_dest | input | N_IN*N_OUT (72) | Acceptable outputs; bit i*N_OUT+j is input i, output j |
| in_data | input | N_IN*DW (256) | Data word per input; field i at bits i*DW upward |
| in_grant | output | N_IN (8) | Win notice for the batch captured two edges earlier |
| out_valid | output | N_OUT (9) | A word is being delivered on this output |
| out_data | output | N_OUT*DW (288) | Delivered word per output; field j at bits j*DW upward |
| out_src | output | N_OUT*SW (27) | Source input index per output |

## Verification
Pointer fairness is the hardest behaviour to reach from the ports. It shows only when many inputs keep contending for the same output across back-to-back batches, and when inputs that name several outputs force the second pass to turn down offers. The stimulus mixes one-hot and multi-output random requests at high load with a bench model of both pointer sets, so every refusal and every pointer move shows up in the expected grants. A directed phase then drives all inputs at output 0 for eight batches and checks that eight distinct sources come out. Another phase raises destination bits with the strobes low to confirm that nothing changes.

// File: rtl/xsw_pkg.sv
package xsw_pkg;

   // Width of an index into a set of n items; never less than one bit.
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/xsw_rr_arb.sv
module xsw_rr_arb #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] req,
   input  logic         adv,
   output logic [W-1:0] gnt
);
   localparam int IW = xsw_pkg::idx_w(W);

   generate
      if (W == 1) begin : g_single
         // One requester: nothing to rotate.
         assign gnt = req;
         logic unused_w1;
         assign unused_w1 = clk ^ rst_n ^ adv;
      end else begin : g_rotate
         logic [IW-1:0] ptr_q;
         logic [IW-1:0] win_idx;
         logic          found;

         always_comb begin
            gnt     = '0;
            win_idx = '0;
            found   = 1'b0;
            for (int k = 0; k < W; k++) begin
               int pos;
               pos = int'(ptr_q) + k;
               if (pos >= W) pos = pos - W;
               if (!found && req[pos[IW-1:0]]) begin
                  found             = 1'b1;
                  gnt[pos[IW-1:0]]  = 1'b1;
                  win_idx           = pos[IW-1:0];
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ptr_q <= '0;
            end else if (adv && found) begin
               if (win_idx == IW'(W - 1)) ptr_q <= '0;
               else                       ptr_q <= IW'(win_idx + 1'b1);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/xsw_alloc.sv
module xsw_alloc #(
   parameter int N_IN  = 8,
   parameter int N_OUT = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_IN*N_OUT-1:0]   req_flat,
   output logic [N_IN*N_OUT-1:0]   grant_q
);
   localparam int NCELL = N_IN * N_OUT;

   logic [N_OUT-1:0][N_IN-1:0] col_req;
   logic [N_OUT-1:0][N_IN-1:0] offer_by_out;
   logic [N_IN-1:0][N_OUT-1:0] offer_to_in;
   logic [N_IN-1:0][N_OUT-1:0] gmat;
   logic [N_OUT-1:0]           out_taken;
   logic [N_IN-1:0]            in_took;
   logic [NCELL-1:0]           gflat;

   // Column view of the request matrix for the output-side pass.
   always_comb begin
      for (int j = 0; j < N_OUT; j++)
         for (int i = 0; i < N_IN; i++)
            col_req[j][i] = req_flat[i*N_OUT + j];
   end

   // Transpose of output offers for the input-side pass.
   always_comb begin
      for (int i = 0; i < N_IN; i++)
         for (int j = 0; j < N_OUT; j++)
            offer_to_in[i][j] = offer_by_out[j][i];
   end

   // Acceptance status for pointer advance.
   always_comb begin
      for (int j = 0; j < N_OUT; j++) begin
         out_taken[j] = 1'b0;
         for (int i = 0; i < N_IN; i++)
            out_taken[j] = out_taken[j] | gmat[i][j];
      end
      for (int i = 0; i < N_IN; i++)
         in_took[i] = |gmat[i];
   end

   genvar gj, gi;
   generate
      for (gj = 0; gj < N_OUT; gj++) begin : g_out_pass
         xsw_rr_arb #(.W(N_IN)) u_oarb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (col_req[gj]),
            .adv   (out_taken[gj]),
            .gnt   (offer_by_out[gj])
         );
      end
      for (gi = 0; gi < N_IN; gi++) begin : g_in_pass
         xsw_rr_arb #(.W(N_OUT)) u_iarb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (offer_to_in[gi]),
            .adv   (in_took[gi]),
            .gnt   (gmat[gi])
         );
      end
   endgenerate

   always_comb begin
      for (int i = 0; i < N_IN; i++)
         for (int j = 0; j < N_OUT; j++)
            gflat[i*N_OUT + j] = gmat[i][j];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) grant_q <= '0;
      else        grant_q <= gflat;
   end

endmodule

// File: rtl/xsw_xbar_dp.sv
module xsw_xbar_dp #(
   parameter int N_IN  = 8,
   parameter int N_OUT = 9,
   parameter int DW    = 32,
   parameter int SW    = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_IN*N_OUT-1:0]  sel,
   input  logic [N_IN*DW-1:0]     din,
   output logic [N_OUT-1:0]       dv_q,
   output logic [N_OUT*DW-1:0]    dout_q,
   output logic [N_OUT*SW-1:0]    src_q
);
   logic [N_OUT-1:0]    nxt_v;
   logic [N_OUT*DW-1:0] nxt_d;
   logic [N_OUT*SW-1:0] nxt_s;

   genvar gj;
   generate
      for (gj = 0; gj < N_OUT; gj++) begin : g_col
         // AND-OR mux: at most one select bit per column is set.
         always_comb begin
            logic          v;
            logic [DW-1:0] d;
            logic [SW-1:0] s;
            v = 1'b0;
            d = '0;
            s = '0;
            for (int i = 0; i < N_IN; i++) begin
               if (sel[i*N_OUT + gj]) begin
                  v = 1'b1;
                  d = d | din[i*DW +: DW];
                  s = s | SW'(i);
               end
            end
            nxt_v[gj]             = v;
            nxt_d[gj*DW +: DW]    = d;
            nxt_s[gj*SW +: SW]    = s;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dv_q   <= '0;
         dout_q <= '0;
         src_q  <= '0;
      end else begin
         dv_q   <= nxt_v;
         dout_q <= nxt_d;
         src_q  <= nxt_s;
      end
   end

endmodule

// File: rtl/xsw_crossbar.sv
module xsw_crossbar #(
   parameter int N_IN  = 8,
   parameter int N_OUT = 9,
   parameter int DW    = 32,
   localparam int SW   = xsw_pkg::idx_w(N_IN)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_IN-1:0]        in_valid,
   input  logic [N_IN*N_OUT-1:0]  in_dest,
   input  logic [N_IN*DW-1:0]     in_data,
   output logic [N_IN-1:0]        in_grant,
   output logic [N_OUT-1:0]       out_valid,
   output logic [N_OUT*DW-1:0]    out_data,
   output logic [N_OUT*SW-1:0]    out_src
);
   localparam int NCELL = N_IN * N_OUT;

   generate
      if (N_IN < 2)  begin : g_chk_in  $error("xsw_crossbar: N_IN must be at least 2");  end
      if (N_OUT < 2) begin : g_chk_out $error("xsw_crossbar: N_OUT must be at least 2"); end
      if (DW < 1)    begin : g_chk_dw  $error("xsw_crossbar: DW must be positive");      end
   endgenerate

   // Stage 1: request capture (strobe masks destination bits).
   logic [NCELL-1:0]     req_mask;
   logic [NCELL-1:0]     s1_req;
   logic [N_IN*DW-1:0]   s1_data;

   always_comb begin
      for (int i = 0; i < N_IN; i++)
         req_mask[i*N_OUT +: N_OUT] = in_valid[i] ? in_dest[i*N_OUT +: N_OUT] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_req  <= '0;
         s1_data <= '0;
      end else begin
         s1_req  <= req_mask;
         s1_data <= in_data;
      end
   end

   // Stage 2: allocation (grant matrix registered inside).
   logic [NCELL-1:0]     s2_grant;
   logic [N_IN*DW-1:0]   s2_data;

   xsw_alloc #(.N_IN(N_IN), .N_OUT(N_OUT)) u_alloc (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_flat (s1_req),
      .grant_q  (s2_grant)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s2_data <= '0;
      else        s2_data <= s1_data;
   end

   // Stage 3: notification and switch setting.
   logic [NCELL-1:0]     s3_grant;
   logic [N_IN*DW-1:0]   s3_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s3_grant <= '0;
         s3_data  <= '0;
      end else begin
         s3_grant <= s2_grant;
         s3_data  <= s2_data;
      end
   end

   always_comb begin
      for (int i = 0; i < N_IN; i++)
         in_grant[i] = |s3_grant[i*N_OUT +: N_OUT];
   end

   // Stage 4: transfer through the crossbar.
   xsw_xbar_dp #(.N_IN(N_IN), .N_OUT(N_OUT), .DW(DW), .SW(SW)) u_dp (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (s3_grant),
      .din    (s3_data),
      .dv_q   (out_valid),
      .dout_q (out_data),
      .src_q  (out_src)
   );

endmodule

// File: rtl/xsw_checker.sv
module xsw_checker #(
   parameter int N_IN  = 8,
   parameter int N_OUT = 9,
   parameter int DW    = 32,
   parameter int SW    = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [N_IN-1:0]       in_valid,
   input logic [N_IN*N_OUT-1:0] in_dest,
   input logic [N_IN*DW-1:0]    in_data,
   input logic [N_IN-1:0]       in_grant,
   input logic [N_OUT-1:0]      out_valid,
   input logic [N_OUT*DW-1:0]   out_data,
   input logic [N_OUT*SW-1:0]   out_src
);
   // Short history of the inputs; entry k holds the value k+1 edges back.
   logic [N_IN-1:0]       hv [4];
   logic [N_IN*N_OUT-1:0] hd [4];
   logic [N_IN*DW-1:0]    hx [4];

   always_ff @(posedge clk) begin
      hv[0] <= in_valid;
      hd[0] <= in_dest;
      hx[0] <= in_data;
      for (int k = 1; k < 4; k++) begin
         hv[k] <= hv[k-1];
         hd[k] <= hd[k-1];
         hx[k] <= hx[k-1];
      end
   end

   // R4: a win notice only follows a strobed request three edges earlier.
   p_notice_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_grant & ~hv[2]) == '0);

   // R4 / R5: each notified winner produces exactly one delivery next cycle.
   p_notice_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(out_valid) == $countones($past(in_grant)));

   genvar gj, gk;
   generate
      for (gj = 0; gj < N_OUT; gj++) begin : g_o
         // R3 / R10: delivered word is the source's word from four edges back,
         // and that source had asked for this output.
         p_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[gj] |->
               (hv[3][int'(out_src[gj*SW +: SW])] &&
                hd[3][int'(out_src[gj*SW +: SW])*N_OUT + gj] &&
                out_data[gj*DW +: DW] == hx[3][int'(out_src[gj*SW +: SW])*DW +: DW]));

         // R9: unused outputs stay quiet.
         p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid[gj] |-> (out_data[gj*DW +: DW] == '0 && out_src[gj*SW +: SW] == '0));

         for (gk = gj + 1; gk < N_OUT; gk++) begin : g_pair
            // R5: no input drives two outputs in one batch.
            p_one_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
               (out_valid[gj] && out_valid[gk]) |->
                  out_src[gj*SW +: SW] != out_src[gk*SW +: SW]);
         end
      end
   endgenerate

endmodule

bind xsw_crossbar xsw_checker #(
   .N_IN (N_IN),
   .N_OUT(N_OUT),
   .DW   (DW),
   .SW   (SW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_dest  (in_dest),
   .in_data  (in_data),
   .in_grant (in_grant),
   .out_valid(out_valid),
   .out_data (out_data),
   .out_src  (out_src)
);

// File: tb/tb_xsw_crossbar.sv
module tb_xsw_crossbar;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int NI = 8;
   localparam int NO = 9;
   localparam int DW = 32;
   localparam int SW = 3;
   localparam int NRAND = 3000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [NI-1:0]    in_valid;
   logic [NI*NO-1:0] in_dest;
   logic [NI*DW-1:0] in_data;
   logic [NI-1:0]    in_grant;
   logic [NO-1:0]    out_valid;
   logic [NO*DW-1:0] out_data;
   logic [NO*SW-1:0] out_src;

   xsw_crossbar #(.N_IN(NI), .N_OUT(NO), .DW(DW)) dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data),
      .in_grant(in_grant), .out_valid(out_valid),
      .out_data(out_data), .out_src(out_src)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // Reference state: round-robin pointers and expected results per batch slot.
   int            optr [NO];
   int            iptr [NI];
   logic [NI-1:0] e_gnt [8];
   logic [NO-1:0] e_ov  [8];
   logic [DW-1:0] e_od  [8][NO];
   int            e_os  [8][NO];

   task automatic chk(input bit ok, input string req, input string msg);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: %s", req, msg);
      end
   endtask

   // R6, R7, R8: two-pass round-robin allocation over the current inputs.
   task automatic model_batch(input int slot);
      int pick [NO];
      int acc  [NI];
      for (int j = 0; j < NO; j++) begin
         pick[j] = -1;
         for (int k = 0; k < NI; k++) begin
            int i;
            i = (optr[j] + k) % NI;
            if (pick[j] < 0 && in_valid[i] && in_dest[i*NO + j]) pick[j] = i;
         end
      end
      for (int i = 0; i < NI; i++) begin
         acc[i] = -1;
         for (int k = 0; k < NO; k++) begin
            int j;
            j = (iptr[i] + k) % NO;
            if (acc[i] < 0 && pick[j] == i) acc[i] = j;
         end
      end
      e_gnt[slot] = '0;
      e_ov[slot]  = '0;
      for (int j = 0; j < NO; j++) begin
         e_od[slot][j] = '0;
         e_os[slot][j] = 0;
      end
      for (int i = 0; i < NI; i++) begin
         if (acc[i] >= 0) begin
            e_gnt[slot][i]       = 1'b1;
            e_ov[slot][acc[i]]   = 1'b1;
            e_od[slot][acc[i]]   = in_data[i*DW +: DW];
            e_os[slot][acc[i]]   = i;
            iptr[i]      = (acc[i] + 1) % NO;
            optr[acc[i]] = (i + 1) % NI;
         end
      end
   endtask

   task automatic step_check(input int k);
      int gs;
      int os;
      gs = (k + 5) % 8;
      os = (k + 4) % 8;
      // R4 (with R2 masking and R11 back-to-back batches)
      chk(in_grant == e_gnt[gs], "R4",
          $sformatf("cycle %0d in_grant act=%h exp=%h", k, in_grant, e_gnt[gs]));
      for (int j = 0; j < NO; j++) begin
         bit ok;
         ok = (out_valid[j] == e_ov[os][j]) &&
              (out_data[j*DW +: DW] == e_od[os][j]) &&
              (out_src[j*SW +: SW] == SW'(e_os[os][j]));
         // R3 / R10 for delivered words, R9 for idle outputs
         chk(ok, e_ov[os][j] ? "R3" : "R9",
             $sformatf("cycle %0d out %0d act v=%b d=%h s=%0d exp v=%b d=%h s=%0d",
                       k, j, out_valid[j], out_data[j*DW +: DW], out_src[j*SW +: SW],
                       e_ov[os][j], e_od[os][j], e_os[os][j]));
      end
   endtask

   function automatic logic [NO-1:0] rand_dest();
      logic [NO-1:0] d;
      int r;
      r = int'($urandom % 8);
      if (r < 5)       d = NO'(1) << ($urandom % NO);
      else if (r < 7)  d = NO'($urandom);
      else             d = '0;
      return d;
   endfunction

   initial begin
      logic [NI-1:0] hot_mask;
      int seed_v;
      seed_v = int'($urandom(32'd7151));
      hot_mask = '0;
      in_valid = '0;
      in_dest  = '0;
      in_data  = '0;
      for (int j = 0; j < NO; j++) optr[j] = 0;
      for (int i = 0; i < NI; i++) iptr[i] = 0;
      for (int s = 0; s < 8; s++) begin
         e_gnt[s] = '0;
         e_ov[s]  = '0;
         for (int j = 0; j < NO; j++) begin
            e_od[s][j] = '0;
            e_os[s][j] = 0;
         end
      end

      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state at the ports
      chk(in_grant == '0 && out_valid == '0 && out_data == '0 && out_src == '0, "R1",
          $sformatf("reset act g=%h v=%h s=%h exp all zero", in_grant, out_valid, out_src));
      rst_n = 1'b1;

      for (int k = 0; k < 60 + NRAND + 8; k++) begin
         step_check(k);

         // R12: collect sources delivered on output 0 during the hotspot phase
         if (k >= 44 && k < 52 && out_valid[0]) hot_mask[out_src[SW-1:0]] = 1'b1;
         if (k == 52)
            chk(hot_mask == '1, "R12",
                $sformatf("hotspot sources act=%b exp=%b", hot_mask, {NI{1'b1}}));

         in_valid = '0;
         in_dest  = '0;
         for (int i = 0; i < NI; i++) in_data[i*DW +: DW] = $urandom;
         if (k < 40) begin
            // distinct destinations: every input wins (R5, R11)
            for (int i = 0; i < NI; i++) begin
               in_valid[i] = 1'b1;
               in_dest[i*NO + ((i + k) % NO)] = 1'b1;
            end
         end else if (k < 56) begin
            // all inputs contend for output 0 (R6, R8, R12)
            for (int i = 0; i < NI; i++) begin
               in_valid[i] = (k < 48);
               in_dest[i*NO] = 1'b1;
            end
         end else if (k < 60) begin
            // R2: destination bits raised with strobes low must do nothing
            in_dest = '1;
         end else if (k < 60 + NRAND) begin
            // random load with multi-output requests (R7, R8)
            for (int i = 0; i < NI; i++) begin
               in_valid[i] = ($urandom % 4) != 0;
               in_dest[i*NO +: NO] = rand_dest();
            end
         end
         model_batch(k % 8);
         @(negedge clk);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: act=timeout exp=completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule